// File: doc/BRIEF.md
# Host/DSP Doorbell Register Block

This block carries short messages between a host processor and a DSP. It has two doorbell registers, one per direction. The transmit doorbell carries host-to-DSP messages and the receive doorbell carries DSP-to-host messages. Each doorbell holds a payload field plus a BUSY flag and a DONE flag. The message bodies themselves sit in a shared mailbox memory outside this block.

To send, the host writes the transmit doorbell with BUSY set. The DSP answers with a reply strobe, which raises DONE and drops BUSY. The host then clears DONE to acknowledge. In the other direction, the DSP loads the receive doorbell with BUSY set. The host acknowledges by dropping BUSY and raising DONE in a single write.

A host-side mask register and a status register combine into one registered interrupt line. While the host services an event, software sets the matching mask bit, and clears it again after the acknowledge. The block also compares the receive doorbell against a panic signature. It forms a mailbox address from the low half of the transmit doorbell plus a fixed base.

Top module: `db_doorbell_top`

## Requirements
- R1: After synchronous reset, both doorbells and the mask register read zero, and `irq_o` and `panic_o` are low.
- R2: A host write to the transmit doorbell (address 0) loads every bit except DONE (bit 30), including BUSY (bit 31). A 0 in bit 30 of that write clears DONE; a 1 in bit 30 leaves DONE unchanged.
- R3: A `dsp_reply_i` pulse sets DONE and clears BUSY in the transmit doorbell. A host write to address 0 in the same cycle still supplies BUSY and the payload.
- R4: When the host clears transmit DONE in the same cycle as `dsp_reply_i`, DONE ends up cleared.
- R5: A DSP write (`dsp_we_i`) loads every bit of the receive doorbell except DONE (bit 30), which it leaves unchanged.
- R6: A host write to the receive doorbell (address 1) affects only the flags. A 0 in bit 31 clears BUSY, and this clear beats a DSP write in the same cycle; a 1 in bit 31 is ignored. DONE takes bit 30 of the write. The payload bits are untouched.
- R7: The mask register (address 2) holds the DONE mask in bit 0 and the BUSY mask in bit 1. The status register (address 3) shows transmit DONE in bit 0 and receive BUSY in bit 1, independent of the mask.
- R8: `irq_o` is high one cycle after any status bit whose mask bit is clear is set, and low one cycle after no such bit is set.
- R9: `panic_o` is high one cycle after the receive doorbell ANDed with 0x0FFFF000 equals 0x0DEAD000, and low one cycle after it does not.
- R10: `panic_addr_o` equals 0x9E000 plus bits 15:0 of the transmit doorbell, one cycle after that doorbell value.
- R11: `host_rdata_o` returns the register selected by `host_addr_i` one cycle later. Writes to the status address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we_i | input | 1 | Host register write strobe |
| host_addr_i | input | 2 | Host register select (0 tx, 1 rx, 2 mask, 3 status) |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Registered read data |
| dsp_reply_i | input | 1 | DSP reply strobe for the transmit doorbell |
| dsp_we_i | input | 1 | DSP write strobe for the receive doorbell |
| dsp_wdata_i | input | 32 | DSP write data for the receive doorbell |
| irq_o | output | 1 | Registered host interrupt |
| panic_o | output | 1 | Registered panic indication |
| panic_addr_o | output | 20 | Registered mailbox address of the panic record |

## Verification
Doorbell and mask registers change at the clock edge on which a write or strobe is sampled. Read data, `irq_o`, `panic_o` and `panic_addr_o` each trail that state by one further edge. The bench therefore applies each stimulus for exactly one edge and then presents a read address. It samples at the following falling edge, where the read data and the three registered outputs all reflect the updated state. A bench-side model built from the flag rules gives the expected values, and every combination of mask bits and source flags is swept.

// File: rtl/db_pkg.sv
package db_pkg;
  typedef enum logic [1:0] {
    SEL_TX   = 2'd0,
    SEL_RX   = 2'd1,
    SEL_MASK = 2'd2,
    SEL_STAT = 2'd3
  } db_sel_e;

  localparam int SRC_DONE = 0;
  localparam int SRC_BUSY = 1;
  localparam int NSRC     = 2;
endpackage

// File: rtl/db_tx_reg.sv
module db_tx_reg #(
  parameter int DW       = 32,
  parameter int BUSY_BIT = 31,
  parameter int DONE_BIT = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [DW-1:0] host_wdata,
  input  logic          dsp_reply,
  output logic [DW-1:0] value_o
);
  logic [DW-1:0] q, nxt;

  always_comb begin
    nxt = q;
    if (dsp_reply) begin
      nxt[DONE_BIT] = 1'b1;
      nxt[BUSY_BIT] = 1'b0;
    end
    if (host_we) begin
      for (int i = 0; i < DW; i++)
        if (i != DONE_BIT) nxt[i] = host_wdata[i];
      if (!host_wdata[DONE_BIT]) nxt[DONE_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign value_o = q;

  a_r3_reply_sets_done: assert property (@(posedge clk) disable iff (rst)
    (dsp_reply && !(host_we && !host_wdata[DONE_BIT])) |=> q[DONE_BIT]);
  a_r4_host_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (host_we && !host_wdata[DONE_BIT]) |=> !q[DONE_BIT]);
  a_r2_host_never_sets_done: assert property (@(posedge clk) disable iff (rst)
    (!dsp_reply && !q[DONE_BIT]) |=> !q[DONE_BIT]);
endmodule

// File: rtl/db_rx_reg.sv
module db_rx_reg #(
  parameter int DW       = 32,
  parameter int BUSY_BIT = 31,
  parameter int DONE_BIT = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [DW-1:0] host_wdata,
  input  logic          dsp_we,
  input  logic [DW-1:0] dsp_wdata,
  output logic [DW-1:0] value_o
);
  logic [DW-1:0] q, nxt;

  always_comb begin
    nxt = q;
    if (dsp_we) begin
      for (int i = 0; i < DW; i++)
        if (i != DONE_BIT) nxt[i] = dsp_wdata[i];
    end
    if (host_we) begin
      if (!host_wdata[BUSY_BIT]) nxt[BUSY_BIT] = 1'b0;
      nxt[DONE_BIT] = host_wdata[DONE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign value_o = q;

  a_r6_busy_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (host_we && !host_wdata[BUSY_BIT]) |=> !q[BUSY_BIT]);
  a_r5_dsp_raises_busy: assert property (@(posedge clk) disable iff (rst)
    (dsp_we && dsp_wdata[BUSY_BIT] && !host_we) |=> q[BUSY_BIT]);
  a_r5_dsp_keeps_done: assert property (@(posedge clk) disable iff (rst)
    (dsp_we && !host_we) |=> $stable(q[DONE_BIT]));
endmodule

// File: rtl/db_irq_mask.sv
module db_irq_mask #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] mask_o,
  output logic            irq_o
);
  logic [NSRC-1:0] mask_q;
  logic            irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      irq_q <= |(src_i & ~mask_q);
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  a_r8_all_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (&mask_q) |=> !irq_q);
  a_r8_open_source_fires: assert property (@(posedge clk) disable iff (rst)
    (|(src_i & ~mask_q)) |=> irq_q);
  a_r8_no_source_quiet: assert property (@(posedge clk) disable iff (rst)
    (src_i == '0) |=> !irq_q);
endmodule

// File: rtl/db_panic.sv
module db_panic #(
  parameter int          DW     = 32,
  parameter int          OFFS_W = 16,
  parameter int          AW     = 20,
  parameter logic [AW-1:0] BASE  = 20'h9E000,
  parameter logic [DW-1:0] MAGIC = 32'h0DEA_D000,
  parameter logic [DW-1:0] MMASK = 32'h0FFF_F000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] rx_i,
  input  logic [DW-1:0] tx_i,
  output logic          panic_o,
  output logic [AW-1:0] addr_o
);
  localparam int PAD = AW - OFFS_W;

  logic          hit;
  logic          panic_q;
  logic [AW-1:0] addr_q;

  assign hit = ((rx_i & MMASK) == MAGIC);

  always_ff @(posedge clk) begin
    if (rst) begin
      panic_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      panic_q <= hit;
      addr_q  <= BASE + {{PAD{1'b0}}, tx_i[OFFS_W-1:0]};
    end
  end

  assign panic_o = panic_q;
  assign addr_o  = addr_q;

  a_r9_signature_flags: assert property (@(posedge clk) disable iff (rst)
    ((rx_i & MMASK) == MAGIC) |=> panic_q);
  a_r9_no_signature_quiet: assert property (@(posedge clk) disable iff (rst)
    ((rx_i & MMASK) != MAGIC) |=> !panic_q);
endmodule

// File: rtl/db_doorbell_top.sv
module db_doorbell_top
  import db_pkg::*;
#(
  parameter int DW       = 32,
  parameter int BUSY_BIT = 31,
  parameter int DONE_BIT = 30,
  parameter int OFFS_W   = 16,
  parameter int AW       = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we_i,
  input  logic [1:0]    host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic          dsp_reply_i,
  input  logic          dsp_we_i,
  input  logic [DW-1:0] dsp_wdata_i,
  output logic          irq_o,
  output logic          panic_o,
  output logic [AW-1:0] panic_addr_o
);
  localparam int PADW = DW - NSRC;

  logic [DW-1:0]   tx_val, rx_val, rdata_q;
  logic [NSRC-1:0] mask_val, src;
  db_sel_e         sel;

  assign sel = db_sel_e'(host_addr_i);
  assign src[SRC_DONE] = tx_val[DONE_BIT];
  assign src[SRC_BUSY] = rx_val[BUSY_BIT];

  db_tx_reg #(.DW(DW), .BUSY_BIT(BUSY_BIT), .DONE_BIT(DONE_BIT)) u_tx (
    .clk(clk), .rst(rst),
    .host_we(host_we_i && sel == SEL_TX), .host_wdata(host_wdata_i),
    .dsp_reply(dsp_reply_i), .value_o(tx_val));

  db_rx_reg #(.DW(DW), .BUSY_BIT(BUSY_BIT), .DONE_BIT(DONE_BIT)) u_rx (
    .clk(clk), .rst(rst),
    .host_we(host_we_i && sel == SEL_RX), .host_wdata(host_wdata_i),
    .dsp_we(dsp_we_i), .dsp_wdata(dsp_wdata_i), .value_o(rx_val));

  db_irq_mask #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst(rst),
    .mask_we(host_we_i && sel == SEL_MASK), .mask_wdata(host_wdata_i[NSRC-1:0]),
    .src_i(src), .mask_o(mask_val), .irq_o(irq_o));

  db_panic #(.DW(DW), .OFFS_W(OFFS_W), .AW(AW)) u_panic (
    .clk(clk), .rst(rst), .rx_i(rx_val), .tx_i(tx_val),
    .panic_o(panic_o), .addr_o(panic_addr_o));

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (sel)
        SEL_TX:   rdata_q <= tx_val;
        SEL_RX:   rdata_q <= rx_val;
        SEL_MASK: rdata_q <= {{PADW{1'b0}}, mask_val};
        default:  rdata_q <= {{PADW{1'b0}}, src};
      endcase
    end
  end

  assign host_rdata_o = rdata_q;

  a_r11_status_write_inert: assert property (@(posedge clk) disable iff (rst)
    (host_we_i && sel == SEL_STAT && !dsp_reply_i && !dsp_we_i) |=>
      ($stable(tx_val) && $stable(rx_val) && $stable(mask_val)));
endmodule

// File: tb/tb_db_doorbell_top.sv
module tb_db_doorbell_top;
  localparam int B = 31;
  localparam int D = 30;
  localparam logic [31:0] MAGIC = 32'h0DEA_D000;
  localparam logic [31:0] MMASK = 32'h0FFF_F000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we_i = 1'b0;
  logic [1:0]  host_addr_i = 2'd0;
  logic [31:0] host_wdata_i = '0;
  logic [31:0] host_rdata_o;
  logic        dsp_reply_i = 1'b0;
  logic        dsp_we_i = 1'b0;
  logic [31:0] dsp_wdata_i = '0;
  logic        irq_o, panic_o;
  logic [19:0] panic_addr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] mtx, mrx;
  logic [1:0]  mmask;

  always #10 clk = ~clk;

  db_doorbell_top dut (
    .clk(clk), .rst(rst), .host_we_i(host_we_i), .host_addr_i(host_addr_i),
    .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
    .dsp_reply_i(dsp_reply_i), .dsp_we_i(dsp_we_i), .dsp_wdata_i(dsp_wdata_i),
    .irq_o(irq_o), .panic_o(panic_o), .panic_addr_o(panic_addr_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one stimulus edge, model updated from the flag rules
  task automatic step(input bit hwe, input logic [1:0] ha, input logic [31:0] hd,
                      input bit drep, input bit dwe, input logic [31:0] dd);
    @(negedge clk);
    host_we_i = hwe; host_addr_i = ha; host_wdata_i = hd;
    dsp_reply_i = drep; dsp_we_i = dwe; dsp_wdata_i = dd;
    if (drep) begin mtx[D] = 1'b1; mtx[B] = 1'b0; end
    if (hwe && ha == 2'd0) begin
      mtx = {hd[31], mtx[D] & hd[D], hd[29:0]};
    end
    if (dwe) mrx = {dd[31], mrx[D], dd[29:0]};
    if (hwe && ha == 2'd1) begin
      if (!hd[B]) mrx[B] = 1'b0;
      mrx[D] = hd[D];
    end
    if (hwe && ha == 2'd2) mmask = hd[1:0];
    @(negedge clk);
    host_we_i = 1'b0; dsp_reply_i = 1'b0; dsp_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    host_addr_i = a;
    @(negedge clk);
    v = host_rdata_o;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    logic [1:0]  st;
    st = {mrx[B], mtx[D]};
    rd(2'd0, v); chk({tag, " R2 R11 tx"}, v, mtx);
    rd(2'd1, v); chk({tag, " R6 R11 rx"}, v, mrx);
    rd(2'd2, v); chk({tag, " R7 mask"}, v, {30'b0, mmask});
    rd(2'd3, v); chk({tag, " R7 status"}, v, {30'b0, st});
    chk({tag, " R8 irq"}, {31'b0, irq_o}, {31'b0, |(st & ~mmask)});
    chk({tag, " R9 panic"}, {31'b0, panic_o}, {31'b0, (mrx & MMASK) == MAGIC});
    chk({tag, " R10 addr"}, {12'b0, panic_addr_o}, 32'h9E000 + {16'b0, mtx[15:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    mtx = '0; mrx = '0; mmask = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset");

    step(1, 0, 32'h8000_1234, 0, 0, '0);          check_all("R2 send");
    step(1, 0, 32'hC000_1234, 0, 0, '0);          check_all("R2 done-one no set");
    step(0, 0, '0, 1, 0, '0);                     check_all("R3 reply");
    step(1, 2, 32'h1, 0, 0, '0);                  check_all("R7 R8 mask done");
    step(1, 0, 32'h0000_1234, 0, 0, '0);          check_all("R2 host clear done");
    step(1, 2, 32'h0, 0, 0, '0);                  check_all("R7 unmask");
    step(1, 0, 32'h8000_0055, 1, 0, '0);          check_all("R4 clear beats reply");
    step(1, 0, 32'hC000_0040, 1, 0, '0);          check_all("R3 reply with host busy");
    step(0, 0, '0, 0, 1, 32'h8000_0777);          check_all("R5 dsp msg");
    step(0, 0, '0, 0, 1, 32'h8DEA_D123);          check_all("R9 R10 panic");
    step(1, 1, 32'h4000_0000, 0, 0, '0);          check_all("R6 host ack");
    step(1, 1, 32'hC000_0000, 0, 0, '0);          check_all("R6 busy set ignored");
    step(0, 0, '0, 0, 1, 32'h8000_0001);          check_all("R5 dsp keeps done");
    step(1, 1, 32'h0000_0000, 0, 1, 32'h8000_0002); check_all("R6 clear beats dsp");
    step(1, 3, 32'hFFFF_FFFF, 0, 0, '0);          check_all("R11 status write");

    // sweep every mask and source combination
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        step(1, 2, {30'b0, 2'(m)}, 0, 0, '0);
        if (s[0]) step(0, 0, '0, 1, 0, '0);
        else      step(1, 0, {16'b0, 16'(m * 16 + s)}, 0, 0, '0);
        if (s[1]) step(0, 0, '0, 0, 1, 32'h8000_0000 | 32'(s));
        else      step(1, 1, 32'h0, 0, 0, '0);
        check_all("R8 sweep");
      end
    end

    // sweep signature near-misses around the panic code
    for (int i = 0; i < 16; i++) begin
      step(0, 0, '0, 0, 1, (MAGIC ^ (32'(i) << 12)) | 32'hF000_0FFF);
      check_all("R9 sweep");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule